// File: doc/BRIEF.md
# Table-Driven Operand Sweep Adder

This block walks two fixed 16-entry operand tables and shows their sum. A reversible prescale counter moves by one on every clock. Its four most significant bits form an address, and both tables share that address. The two 8-bit words read from the tables go into an 8-bit ripple-carry adder. The adder is a chain of full-adder cells with its carry-in held at zero. The result is a 9-bit value in the range 0 to 510.

The counter is wide, so each address is held for many clocks and the output sequence moves slowly enough to watch. The counter width is a parameter with a default of 30. With that default, a 100 MHz clock takes about 10.7 s to visit all sixteen addresses. A short width makes the same sequence fast for simulation.

The up/down select sets the direction the sequence runs. A synchronous reset forces the next counter state to zero, whatever the direction select is. The table words are registered, so the sum always belongs to the address that was present one clock earlier.

Top module: `operand_sweep_adder`

## Requirements
- R1: While `up` is 1 and `rst` is 0, the counter rises by one per clock. `addr` therefore advances by one every 2^(CNT_W-4) clocks and wraps from 15 to 0.
- R2: While `up` is 0 and `rst` is 0, the counter falls by one per clock. From zero it wraps to all ones, so `addr` becomes 15 and the sequence runs in reverse.
- R3: `addr` equals the four most significant bits of the CNT_W-bit counter.
- R4: The A-side table holds 0, 2, 3, 8, 116, 255, 155, 255, 0, 1, 2, 3, 1, 2, 3, 4, in order for addresses 0 to 15.
- R5: The B-side table holds 0, 3, 7, 102, 94, 55, 255, 255, 1, 2, 3, 4, 0, 1, 2, 3, in order for addresses 0 to 15.
- R6: `{carry_out, sum}` equals A + B as a 9-bit unsigned value, with carry-in zero. It reaches its maximum of 510 at address 7.
- R7: The operand words are registered. The `sum` and `carry_out` seen in a cycle belong to the `addr` of the previous cycle.
- R8: A clock edge with `rst` at 1 sets the counter to zero whatever `up` is. It also clears both operand registers, so after that edge `addr`, `sum` and `carry_out` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| up | input | 1 | Count direction: 1 counts up, 0 counts down |
| sum | output | 8 | Low eight bits of A + B |
| carry_out | output | 1 | Carry out of the top adder cell |
| addr | output | 4 | Current shared table address |

## Verification
The bench builds the block with CNT_W = 6. Each address is then held for only four clocks, and a whole pass of the sixteen addresses takes 64 clocks. This puts both wrap points, the reverse sequence, direction changes in the middle of a hold period and resets with either direction within a few hundred cycles. A bench model of the counter and of the registered operands is compared with every output on every cycle of these runs.

// File: rtl/opsweep_pkg.sv
package opsweep_pkg;
  parameter int ADDR_W = 4;
  parameter int DATA_W = 8;
  localparam int DEPTH = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [DATA_W-1:0] word_t;

  // Left-hand operand table, index 0 first
  localparam word_t LHS_TAB [DEPTH] = '{
    8'd0,  8'd2,   8'd3,   8'd8,   8'd116, 8'd255, 8'd155, 8'd255,
    8'd0,  8'd1,   8'd2,   8'd3,   8'd1,   8'd2,   8'd3,   8'd4
  };

  // Right-hand operand table, index 0 first
  localparam word_t RHS_TAB [DEPTH] = '{
    8'd0,  8'd3,   8'd7,   8'd102, 8'd94,  8'd55,  8'd255, 8'd255,
    8'd1,  8'd2,   8'd3,   8'd4,   8'd0,   8'd1,   8'd2,   8'd3
  };

  // One full-adder cell: sum bit
  function automatic logic fa_sum(input logic x, input logic y, input logic ci);
    return x ^ y ^ ci;
  endfunction

  // One full-adder cell: majority carry
  function automatic logic fa_carry(input logic x, input logic y, input logic ci);
    return (x & y) | (y & ci) | (x & ci);
  endfunction
endpackage

// File: rtl/sweep_counter.sv
module sweep_counter
  import opsweep_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  up,
  output addr_t addr_o
);
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_d;

  // Reset overrides the direction in the next-state logic
  always_comb begin
    if (rst)     cnt_d = '0;
    else if (up) cnt_d = cnt_q + ONE;
    else         cnt_d = cnt_q - ONE;
  end

  always_ff @(posedge clk) cnt_q <= cnt_d;

  assign addr_o = cnt_q[CNT_W-1 -: ADDR_W];

  a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
    up |=> (cnt_q == ($past(cnt_q) + ONE)));

  a_r2_step_down: assert property (@(posedge clk) disable iff (rst)
    !up |=> (cnt_q == ($past(cnt_q) - ONE)));

  a_r8_reset_zero: assert property (@(posedge clk)
    rst |=> (cnt_q == '0));
endmodule

// File: rtl/operand_table.sv
module operand_table
  import opsweep_pkg::*;
#(
  parameter bit RHS = 1'b0
) (
  input  logic  clk,
  input  logic  rst,
  input  addr_t addr_i,
  output word_t word_o
);
  word_t look;

  generate
    if (RHS) begin : g_rhs
      assign look = RHS_TAB[addr_i];
    end else begin : g_lhs
      assign look = LHS_TAB[addr_i];
    end
  endgenerate

  // Synchronous read: one clock of latency
  always_ff @(posedge clk) begin
    if (rst) word_o <= '0;
    else     word_o <= look;
  end

  a_r7_hold_word: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $stable(addr_i)) |=> $stable(word_o));
endmodule

// File: rtl/ripple_adder.sv
module ripple_adder
  import opsweep_pkg::*;
#(
  parameter int W = DATA_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] s,
  output logic         cout
);
  logic [W:0] chain;
  assign chain[0] = cin;

  generate
    for (genvar i = 0; i < W; i++) begin : g_cell
      assign s[i]       = fa_sum(a[i], b[i], chain[i]);
      assign chain[i+1] = fa_carry(a[i], b[i], chain[i]);
    end
  endgenerate

  assign cout = chain[W];
endmodule

// File: rtl/operand_sweep_adder.sv
module operand_sweep_adder
  import opsweep_pkg::*;
#(
  parameter int CNT_W = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up,
  output logic [DATA_W-1:0] sum,
  output logic              carry_out,
  output logic [ADDR_W-1:0] addr
);
  addr_t cur_addr;
  word_t opa;
  word_t opb;

  sweep_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .up(up), .addr_o(cur_addr)
  );

  operand_table #(.RHS(1'b0)) u_lhs (
    .clk(clk), .rst(rst), .addr_i(cur_addr), .word_o(opa)
  );

  operand_table #(.RHS(1'b1)) u_rhs (
    .clk(clk), .rst(rst), .addr_i(cur_addr), .word_o(opb)
  );

  ripple_adder #(.W(DATA_W)) u_add (
    .a(opa), .b(opb), .cin(1'b0), .s(sum), .cout(carry_out)
  );

  assign addr = cur_addr;

  a_r6_ripple_matches: assert property (@(posedge clk) disable iff (rst)
    {carry_out, sum} == ({1'b0, opa} + {1'b0, opb}));

  a_r8_outputs_cleared: assert property (@(posedge clk)
    rst |=> (addr == '0 && sum == '0 && !carry_out));
endmodule

// File: tb/operand_sweep_adder_test.sv
module operand_sweep_adder_test;
  localparam int CW = 6;
  localparam int SHIFT = CW - 4;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic up = 1'b1;
  logic [7:0] sum;
  logic carry_out;
  logic [3:0] addr;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  int ta [16] = '{0, 2, 3, 8, 116, 255, 155, 255, 0, 1, 2, 3, 1, 2, 3, 4};
  int tb [16] = '{0, 3, 7, 102, 94, 55, 255, 255, 1, 2, 3, 4, 0, 1, 2, 3};

  int m_cnt = 0;
  int m_a = 0;
  int m_b = 0;
  int seen_max = 0;

  always #2.5 clk = ~clk;

  operand_sweep_adder #(.CNT_W(CW)) uut (
    .clk(clk), .rst(rst), .up(up), .sum(sum), .carry_out(carry_out), .addr(addr)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // One clock with the given inputs, then compare at the falling edge
  task automatic run(input int n, input logic r, input logic u);
    for (int k = 0; k < n; k++) begin
      rst = r;
      up = u;
      @(posedge clk);
      if (r) begin
        m_a = 0; m_b = 0; m_cnt = 0;
      end else begin
        m_a = ta[m_cnt >> SHIFT];
        m_b = tb[m_cnt >> SHIFT];
        m_cnt = u ? ((m_cnt + 1) & MASK) : ((m_cnt - 1) & MASK);
      end
      @(negedge clk);
      if (r) begin
        check("R8 addr after reset", int'(addr), 0);
        check("R8 sum/carry after reset", int'({carry_out, sum}), 0);
      end else begin
        check(u ? "R1 R3 addr rising" : "R2 R3 addr falling", int'(addr), m_cnt >> SHIFT);
        // R4 R5 tables, R6 addition, R7 one-clock lag
        check("R4 R5 R6 R7 sum", int'({carry_out, sum}), m_a + m_b);
      end
      if (int'({carry_out, sum}) > seen_max) seen_max = int'({carry_out, sum});
    end
  endtask

  initial begin
    run(3, 1'b1, 1'b1);        // R8 reset with up=1
    run(70, 1'b0, 1'b1);       // R1 full pass plus wrap 15->0
    run(5, 1'b0, 1'b0);        // R2 reversal mid-hold
    run(2, 1'b1, 1'b0);        // R8 reset with up=0
    run(1, 1'b0, 1'b0);
    check("R2 wrap below zero", int'(addr), 15);
    run(70, 1'b0, 1'b0);       // R2 reverse pass
    run(10, 1'b0, 1'b1);
    check("R6 peak 510 observed", seen_max, 510);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule